// File: doc/BRIEF.md
# Quadrature Encoder Position Decoder

This block follows a rotary or linear encoder and keeps a position count and a direction flag. It takes two phase inputs and an index input from pins. Each input passes through a synchronizer and then an optional stability filter. It decodes the filtered phases in one of two ways. Quadrature mode treats them as a two-bit Gray code. Step/direction mode treats one phase as a step strobe and the other as a direction level. A swap control exchanges the phases before decoding. This fixes miswired encoders or reverses the meaning of forward.

The position counter stays in the range zero to a programmed maximum and wraps at both ends. An index pulse can clear it. A velocity accumulator sums the counted edges over a programmed number of clocks. At the end of each period it publishes the sum and starts again from zero. The accumulator only runs while position counting is also enabled. All control comes from static configuration inputs that a surrounding register file is expected to drive.

Top module: `qenc_decoder`

## Requirements
- R1: While rst_n is low, position, direction, gray_err and velocity are all zero.
- R2: In quadrature mode with cfg_both_edges=1, each step of the phase sequence (a,b) = 00 -> 10 -> 11 -> 01 -> 00 adds one to position and sets direction to 1. Each step of the reverse sequence subtracts one and sets direction to 0. Direction keeps its value while the phases are idle.
- R3: In quadrature mode with cfg_both_edges=0, only transitions of the decoded A phase change position. Transitions of B alone leave position unchanged.
- R4: With cfg_swap=1 the two phase pins are exchanged before decoding, so a physical sequence that counted up now counts down.
- R5: With cfg_step_dir=1, each rising edge of the decoded A phase changes position by one: up when decoded B is 1, down when it is 0. Falling edges of A and changes of B alone do not change position.
- R6: In quadrature mode, a sample in which both phases change at once leaves position unchanged and sets gray_err. gray_err then stays at 1 until reset.
- R7: With cfg_filt_en=1, a change on an input reaches the decoder only if the synchronized input holds the new value for cfg_filt_count+1 consecutive clocks. A pulse one clock shorter than that has no effect. With the filter off, a two-clock pulse is counted.
- R8: Counting up from cfg_max_pos gives 0, and counting down from 0 gives cfg_max_pos.
- R9: A rising edge of the filtered index clears position to 0 when cfg_idx_clr_en=1. It has no effect on position when cfg_idx_clr_en=0.
- R10: While cfg_pos_en=0, position and direction hold their values whatever the phase inputs do.
- R11: While velocity capture is active, the signed sum of counted edges (+1 up, -1 down) over each window of cfg_vel_period clocks is loaded into velocity at the end of the window. The sum then restarts from zero, and velocity holds between loads.
- R12: Velocity capture is active only when both cfg_vel_en and cfg_pos_en are 1. Otherwise velocity holds its last value.
- R13: With the filter off, a phase change driven between clock edges shows up on position after exactly four rising clock edges, and not after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_a | input | 1 | Encoder phase A pin |
| phase_b | input | 1 | Encoder phase B pin |
| index_in | input | 1 | Encoder index pin |
| cfg_pos_en | input | 1 | Enable position counting |
| cfg_vel_en | input | 1 | Enable velocity capture (effective only with cfg_pos_en) |
| cfg_step_dir | input | 1 | 1: step/direction mode, 0: quadrature mode |
| cfg_swap | input | 1 | Exchange phase A and phase B before decoding |
| cfg_both_edges | input | 1 | Quadrature: 1 counts edges of both phases, 0 counts A edges only |
| cfg_filt_en | input | 1 | Enable the stability filter on all three inputs |
| cfg_filt_count | input | FILT_W | Filter stability count (holds for count+1 clocks) |
| cfg_idx_clr_en | input | 1 | Allow the index edge to clear position |
| cfg_max_pos | input | POS_W | Largest position value before wrap |
| cfg_vel_period | input | PER_W | Velocity window length in clocks (at least 1) |
| position | output | POS_W | Position count |
| direction | output | 1 | Direction of the last counted edge, 1 = up |
| gray_err | output | 1 | Sticky flag for an illegal quadrature transition |
| velocity | output | VEL_W | Signed edge sum of the last completed window |

## Verification
A wrong filter counter or a wrong decode state shows up as an extra or missing count on position four clocks after the input edge. A wrong filter state can also show up as a count that comes one clock early or late. Because of that delay, each stimulus step is given time to settle and the bench then compares position and direction against a model. A fault in the wrap logic shows as soon as the count passes zero or the maximum. Faults in the velocity window or accumulator stay hidden until the end of a window, so velocity is checked before and after each window boundary. gray_err is checked right after an illegal jump and again after later legal moves, to catch a flag that is not sticky.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

   // One decoded encoder event per clock.
   typedef struct packed {
      logic step;   // a countable edge was seen
      logic fwd;    // direction of that edge, 1 = up
      logic bad;    // both quadrature phases moved in one sample
   } qenc_evt_t;

   // Direction of a quadrature move in which only phase A toggled.
   function automatic logic fwd_on_a(input logic a_now, input logic b_now);
      return a_now ^ b_now;
   endfunction

   // Direction of a quadrature move in which only phase B toggled.
   function automatic logic fwd_on_b(input logic a_now, input logic b_now);
      return ~(a_now ^ b_now);
   endfunction

endpackage

// File: rtl/qenc_in_filter.sv
module qenc_in_filter #(
   parameter int SYNC_N = 2,
   parameter int CNT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw,
   input  logic             filt_en,
   input  logic [CNT_W-1:0] hold_cnt,
   output logic             clean
);

   logic [SYNC_N-1:0] sync_q;
   logic [CNT_W-1:0]  run_q;
   logic              synced;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_N-2:0], raw};
   end

   assign synced = sync_q[SYNC_N-1];

   // The output follows the synchronized input. With the filter on, the
   // input must differ from the output for hold_cnt+1 samples in a row.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clean <= 1'b0;
         run_q <= '0;
      end else if (!filt_en) begin
         clean <= synced;
         run_q <= '0;
      end else if (synced == clean) begin
         run_q <= '0;
      end else if (run_q == hold_cnt) begin
         clean <= synced;
         run_q <= '0;
      end else begin
         run_q <= run_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/qenc_edge_decode.sv
module qenc_edge_decode
   import qenc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      a_in,
   input  logic      b_in,
   input  logic      swap,
   input  logic      step_dir,
   input  logic      both_edges,
   output qenc_evt_t evt
);

   logic a_cur, b_cur, a_prev, b_prev, a_tog, b_tog;

   assign a_cur = swap ? b_in : a_in;
   assign b_cur = swap ? a_in : b_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_prev <= 1'b0;
         b_prev <= 1'b0;
      end else begin
         a_prev <= a_cur;
         b_prev <= b_cur;
      end
   end

   assign a_tog = a_cur ^ a_prev;
   assign b_tog = b_cur ^ b_prev;

   always_comb begin
      evt = '0;
      if (step_dir) begin
         if (a_cur && !a_prev) begin
            evt.step = 1'b1;
            evt.fwd  = b_cur;
         end
      end else if (a_tog && b_tog) begin
         evt.bad = 1'b1;
      end else if (a_tog) begin
         evt.step = 1'b1;
         evt.fwd  = fwd_on_a(a_cur, b_cur);
      end else if (b_tog && both_edges) begin
         evt.step = 1'b1;
         evt.fwd  = fwd_on_b(a_cur, b_cur);
      end
   end

endmodule

// File: rtl/qenc_position.sv
module qenc_position
   import qenc_pkg::*;
#(
   parameter int POS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  qenc_evt_t        evt,
   input  logic             idx_rise,
   input  logic             idx_clr_en,
   input  logic [POS_W-1:0] max_pos,
   output logic [POS_W-1:0] pos,
   output logic             dir,
   output logic             err
);

   logic [POS_W-1:0] pos_up, pos_dn;

   assign pos_up = (pos >= max_pos) ? '0 : pos + POS_W'(1);
   assign pos_dn = (pos == '0) ? max_pos : pos - POS_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos <= '0;
         dir <= 1'b0;
         err <= 1'b0;
      end else if (en) begin
         if (evt.bad)  err <= 1'b1;
         if (evt.step) dir <= evt.fwd;
         if (idx_rise && idx_clr_en) pos <= '0;
         else if (evt.step)          pos <= evt.fwd ? pos_up : pos_dn;
      end
   end

endmodule

// File: rtl/qenc_velocity.sv
module qenc_velocity #(
   parameter int VEL_W = 16,
   parameter int PER_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    active,
   input  logic                    step,
   input  logic                    fwd,
   input  logic [PER_W-1:0]        period,
   output logic signed [VEL_W-1:0] vel
);

   logic [PER_W-1:0]        timer_q;
   logic [PER_W:0]          timer_nxt;
   logic signed [VEL_W-1:0] acc_q, delta;

   assign delta     = !step ? '0 : (fwd ? VEL_W'(1) : '1);
   assign timer_nxt = {1'b0, timer_q} + (PER_W+1)'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         timer_q <= '0;
         acc_q   <= '0;
         vel     <= '0;
      end else if (!active) begin
         timer_q <= '0;
         acc_q   <= '0;
      end else if (timer_nxt >= {1'b0, period}) begin
         vel     <= acc_q + delta;
         acc_q   <= '0;
         timer_q <= '0;
      end else begin
         acc_q   <= acc_q + delta;
         timer_q <= timer_nxt[PER_W-1:0];
      end
   end

endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
   import qenc_pkg::*;
#(
   parameter int POS_W  = 16,
   parameter int FILT_W = 4,
   parameter int VEL_W  = 16,
   parameter int PER_W  = 16,
   parameter int SYNC_N = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    phase_a,
   input  logic                    phase_b,
   input  logic                    index_in,
   input  logic                    cfg_pos_en,
   input  logic                    cfg_vel_en,
   input  logic                    cfg_step_dir,
   input  logic                    cfg_swap,
   input  logic                    cfg_both_edges,
   input  logic                    cfg_filt_en,
   input  logic [FILT_W-1:0]       cfg_filt_count,
   input  logic                    cfg_idx_clr_en,
   input  logic [POS_W-1:0]        cfg_max_pos,
   input  logic [PER_W-1:0]        cfg_vel_period,
   output logic [POS_W-1:0]        position,
   output logic                    direction,
   output logic                    gray_err,
   output logic signed [VEL_W-1:0] velocity
);

   localparam int N_IN = 3;

   if (POS_W < 2)  begin : g_bad_pos  $error("POS_W must be at least 2");  end
   if (FILT_W < 1) begin : g_bad_filt $error("FILT_W must be at least 1"); end
   if (VEL_W < 2)  begin : g_bad_vel  $error("VEL_W must be at least 2");  end
   if (PER_W < 1)  begin : g_bad_per  $error("PER_W must be at least 1");  end
   if (SYNC_N < 2) begin : g_bad_sync $error("SYNC_N must be at least 2"); end

   logic [N_IN-1:0] pins, clean;
   logic            idx_prev, idx_rise, vel_active, cnt_step;
   qenc_evt_t       evt;

   assign pins = {index_in, phase_b, phase_a};

   for (genvar i = 0; i < N_IN; i++) begin : g_in
      qenc_in_filter #(.SYNC_N(SYNC_N), .CNT_W(FILT_W)) u_flt (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw      (pins[i]),
         .filt_en  (cfg_filt_en),
         .hold_cnt (cfg_filt_count),
         .clean    (clean[i])
      );
   end

   qenc_edge_decode u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .a_in       (clean[0]),
      .b_in       (clean[1]),
      .swap       (cfg_swap),
      .step_dir   (cfg_step_dir),
      .both_edges (cfg_both_edges),
      .evt        (evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) idx_prev <= 1'b0;
      else        idx_prev <= clean[2];
   end

   assign idx_rise   = clean[2] & ~idx_prev;
   assign vel_active = cfg_vel_en & cfg_pos_en;
   assign cnt_step   = evt.step & cfg_pos_en;

   qenc_position #(.POS_W(POS_W)) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (cfg_pos_en),
      .evt        (evt),
      .idx_rise   (idx_rise),
      .idx_clr_en (cfg_idx_clr_en),
      .max_pos    (cfg_max_pos),
      .pos        (position),
      .dir        (direction),
      .err        (gray_err)
   );

   qenc_velocity #(.VEL_W(VEL_W), .PER_W(PER_W)) u_vel (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (vel_active),
      .step   (evt.step),
      .fwd    (evt.fwd),
      .period (cfg_vel_period),
      .vel    (velocity)
   );

endmodule

// File: rtl/qenc_decoder_chk.sv
module qenc_decoder_chk #(
   parameter int POS_W = 16,
   parameter int VEL_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cfg_pos_en,
   input logic                    cfg_vel_en,
   input logic [POS_W-1:0]        cfg_max_pos,
   input logic [POS_W-1:0]        position,
   input logic                    direction,
   input logic                    gray_err,
   input logic signed [VEL_W-1:0] velocity,
   input logic                    cnt_step
);

   // R10: a disabled counter keeps its position.
   a_r10_hold_pos: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_pos_en) |-> $stable(position));

   // R10: a disabled counter keeps its direction.
   a_r10_hold_dir: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_pos_en) |-> $stable(direction));

   // R6: the illegal-transition flag never clears outside reset.
   a_r6_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
      $past(gray_err) |-> gray_err);

   // R8: position only moves by one, wraps to an end, or clears.
   a_r8_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(position) |-> (position == '0 ||
                              position == cfg_max_pos ||
                              position == $past(position) + POS_W'(1) ||
                              position == $past(position) - POS_W'(1)));

   // R2: direction changes only on a counted edge.
   a_r2_dir_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(direction) |-> $past(cnt_step));

   // R12: velocity is frozen unless both enables were set.
   a_r12_vel_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(cfg_vel_en) && $past(cfg_pos_en)) |-> $stable(velocity));

endmodule

bind qenc_decoder qenc_decoder_chk #(.POS_W(POS_W), .VEL_W(VEL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_pos_en  (cfg_pos_en),
   .cfg_vel_en  (cfg_vel_en),
   .cfg_max_pos (cfg_max_pos),
   .position    (position),
   .direction   (direction),
   .gray_err    (gray_err),
   .velocity    (velocity),
   .cnt_step    (cnt_step)
);

// File: tb/qenc_decoder_test.sv
module qenc_decoder_test;

   localparam int CLK_P  = 10;
   localparam int POS_W  = 16;
   localparam int FILT_W = 4;
   localparam int VEL_W  = 16;
   localparam int PER_W  = 16;

   logic clk = 1'b0;
   logic rst_n, phase_a, phase_b, index_in;
   logic cfg_pos_en, cfg_vel_en, cfg_step_dir, cfg_swap, cfg_both_edges;
   logic cfg_filt_en, cfg_idx_clr_en;
   logic [FILT_W-1:0] cfg_filt_count;
   logic [POS_W-1:0]  cfg_max_pos, position;
   logic [PER_W-1:0]  cfg_vel_period;
   logic direction, gray_err;
   logic signed [VEL_W-1:0] velocity;

   int n_chk = 0;
   int n_fail = 0;
   int q = 0;
   longint exp_pos = 0;
   logic exp_dir = 1'b0;
   int unused_seed;

   always #(CLK_P/2) clk = ~clk;

   qenc_decoder #(.POS_W(POS_W), .FILT_W(FILT_W), .VEL_W(VEL_W), .PER_W(PER_W)) uut (
      .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b), .index_in(index_in),
      .cfg_pos_en(cfg_pos_en), .cfg_vel_en(cfg_vel_en), .cfg_step_dir(cfg_step_dir),
      .cfg_swap(cfg_swap), .cfg_both_edges(cfg_both_edges), .cfg_filt_en(cfg_filt_en),
      .cfg_filt_count(cfg_filt_count), .cfg_idx_clr_en(cfg_idx_clr_en),
      .cfg_max_pos(cfg_max_pos), .cfg_vel_period(cfg_vel_period),
      .position(position), .direction(direction), .gray_err(gray_err), .velocity(velocity)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic longint wrap_step(input longint p, input bit up, input longint mx);
      if (up) return (p >= mx) ? 0 : p + 1;
      return (p == 0) ? mx : p - 1;
   endfunction

   function automatic bit q_a(input int s); return (s == 1 || s == 2); endfunction
   function automatic bit q_b(input int s); return (s == 2 || s == 3); endfunction

   // Move the physical phases one quadrature step and update the model.
   task automatic quad_move(input bit up_phys, input string req);
      int nq;
      bit a_ch, b_ch, dec_a_ch, up;
      nq = up_phys ? (q + 1) % 4 : (q + 3) % 4;
      a_ch = q_a(nq) != q_a(q);
      b_ch = q_b(nq) != q_b(q);
      dec_a_ch = cfg_swap ? b_ch : a_ch;
      up = up_phys ^ cfg_swap;
      if (cfg_pos_en && (cfg_both_edges || dec_a_ch)) begin
         exp_pos = wrap_step(exp_pos, up, longint'(cfg_max_pos));
         exp_dir = up;
      end
      q = nq;
      phase_a = q_a(q);
      phase_b = q_b(q);
      tick(6);
      chk(req, longint'(position), exp_pos);
      chk(req, longint'(direction), longint'(exp_dir));
   endtask

   task automatic step_pulse(input int hi, input int lo);
      phase_a = 1'b1; tick(hi);
      phase_a = 1'b0; tick(lo);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      unused_seed = $urandom(32'd1234);
      rst_n = 1'b0; phase_a = 1'b0; phase_b = 1'b0; index_in = 1'b0;
      cfg_pos_en = 1'b1; cfg_vel_en = 1'b0; cfg_step_dir = 1'b0; cfg_swap = 1'b0;
      cfg_both_edges = 1'b1; cfg_filt_en = 1'b0; cfg_filt_count = '0;
      cfg_idx_clr_en = 1'b0; cfg_max_pos = 16'd37; cfg_vel_period = 16'd300;
      tick(4);
      chk("R1 position", longint'(position), 0);
      chk("R1 direction", longint'(direction), 0);
      chk("R1 gray_err", longint'(gray_err), 0);
      chk("R1 velocity", longint'(velocity), 0);
      rst_n = 1'b1;
      tick(3);

      // R13: latency of exactly four rising edges.
      q = 1; phase_a = 1'b1;
      tick(3);
      chk("R13 not yet", longint'(position), 0);
      tick(1);
      chk("R13 arrived", longint'(position), 1);
      exp_pos = 1; exp_dir = 1'b1;
      tick(2);

      // R2: forward then reverse, direction held while idle.
      for (int i = 0; i < 3; i++) quad_move(1'b1, "R2 up");
      quad_move(1'b0, "R2 down");
      tick(20);
      chk("R2 idle dir", longint'(direction), 0);

      // R8: count down to zero, wrap to max, wrap back to zero.
      for (int i = 0; i < 3; i++) quad_move(1'b0, "R8 down");
      quad_move(1'b0, "R8 wrap low");
      chk("R8 at max", longint'(position), 37);
      quad_move(1'b1, "R8 wrap high");

      // R2/R8: constrained random walk.
      for (int i = 0; i < 150; i++) quad_move(1'($urandom % 2), "R2 random");

      // R3: A-edge-only counting.
      cfg_both_edges = 1'b0;
      for (int i = 0; i < 8; i++) quad_move(1'b1, "R3 a only");
      cfg_both_edges = 1'b1;
      while (q != 0) quad_move(1'b1, "R2 align");

      // R4: swapped phases invert the sense of direction.
      cfg_swap = 1'b1; tick(6);
      for (int i = 0; i < 4; i++) quad_move(1'b1, "R4 swap");
      cfg_swap = 1'b0; tick(6);

      // R6: illegal jump 00 -> 11, then sticky across legal moves.
      chk("R6 clear before", longint'(gray_err), 0);
      q = 2; phase_a = 1'b1; phase_b = 1'b1; tick(6);
      chk("R6 pos kept", longint'(position), exp_pos);
      chk("R6 flag set", longint'(gray_err), 1);
      for (int i = 0; i < 3; i++) quad_move(1'($urandom % 2), "R6 legal after");
      chk("R6 sticky", longint'(gray_err), 1);

      // R10: disabled counter ignores movement.
      cfg_pos_en = 1'b0;
      for (int i = 0; i < 5; i++) quad_move(1'b1, "R10 hold");
      cfg_pos_en = 1'b1;

      // R9: index edge only clears when allowed.
      index_in = 1'b1; tick(6); index_in = 1'b0; tick(6);
      chk("R9 ignored", longint'(position), exp_pos);
      cfg_idx_clr_en = 1'b1;
      index_in = 1'b1; tick(6); index_in = 1'b0; tick(6);
      exp_pos = 0;
      chk("R9 cleared", longint'(position), 0);
      cfg_idx_clr_en = 1'b0;

      // R5: step/direction mode.
      cfg_pos_en = 1'b0;
      phase_a = 1'b0; phase_b = 1'b1; q = 0; tick(6);
      cfg_step_dir = 1'b1; tick(2);
      cfg_pos_en = 1'b1;
      phase_a = 1'b1; tick(6);
      chk("R5 rise up", longint'(position), 1);
      phase_a = 1'b0; tick(6);
      chk("R5 fall none", longint'(position), 1);
      phase_b = 1'b0; tick(6);
      chk("R5 b none", longint'(position), 1);
      step_pulse(6, 6);
      chk("R5 rise down", longint'(position), 0);
      step_pulse(6, 6);
      chk("R8 step wrap", longint'(position), 37);
      phase_b = 1'b1; tick(4);
      step_pulse(6, 6);
      chk("R8 step wrap up", longint'(position), 0);

      // R7: stability filter.
      cfg_filt_en = 1'b1; cfg_filt_count = 4'd5; tick(4);
      step_pulse(5, 20);
      chk("R7 short pulse", longint'(position), 0);
      step_pulse(6, 20);
      chk("R7 long pulse", longint'(position), 1);
      cfg_filt_en = 1'b0; tick(4);
      step_pulse(2, 10);
      chk("R7 filter off", longint'(position), 2);

      // R11: velocity windows.
      cfg_vel_en = 1'b1;
      tick(20);
      for (int i = 0; i < 6; i++) step_pulse(5, 5);
      phase_b = 1'b0;
      for (int i = 0; i < 2; i++) step_pulse(5, 5);
      tick(50);
      chk("R11 before end", longint'(velocity), 0);
      tick(160);
      chk("R11 sum", longint'(velocity), 4);
      tick(300);
      chk("R11 idle window", longint'(velocity), 0);
      for (int i = 0; i < 3; i++) step_pulse(5, 5);
      tick(300);
      chk("R11 negative", longint'(velocity), -3);

      // R12: capture stops without position enable.
      cfg_pos_en = 1'b0;
      for (int i = 0; i < 5; i++) step_pulse(5, 5);
      tick(700);
      chk("R12 held", longint'(velocity), -3);
      cfg_pos_en = 1'b1; cfg_vel_en = 1'b0;
      for (int i = 0; i < 5; i++) step_pulse(5, 5);
      tick(700);
      chk("R12 vel off", longint'(velocity), -3);

      summary();
      $finish;
   end

endmodule